// File: doc/BRIEF.md
# Serial Port Register File with Two-Step Flag Clearing

This block is the processor-facing register file of a serial communications port. It holds a control register with interrupt enables and a data-width mode bit, a 16-bit status register, and one data address shared by a receive holding register (read side) and a transmit holding register (write side). Status flags are raised by single-cycle pulses from stub transmit and receive engines. The block forwards transmit data to the transmit engine through a valid/ready handshake.

Software clears a flag in two steps. It first reads status while the flag is set, then reads or writes the data address. A per-bit snapshot taken at the status read decides which flags the data access may clear. A flag raised between the two steps therefore stays set. A combined access (address 3) reads status and data in one operation. It clears the receive-side flags that are set at that moment and leaves the transmit flags alone. A registered interrupt request combines the enabled flags.

Address map: 0 = control (read/write), 1 = status (read only), 2 = data, 3 = combined status+data read. Control bits: [0] receive-full enable, [1] idle enable, [2] transmit-empty enable, [3] transmit-done enable, [4] nine-bit mode. Status bits: [0] receive full, [1] idle, [2] overrun, [8] transmit holding empty, [9] transmit done. All other status bits read 0.

Top module: `uart_regif`

## Requirements
- R1: After reset, status reads 0x0300 (transmit empty and transmit done set), control reads 0x0000, irq_o is 0 and tx_valid_o is 0.
- R2: A status read (addr 1) records which flags are set. A later data read or data write (addr 2) clears the receive full, idle and overrun bits that were recorded.
- R3: A flag raised after the status read survives the following data access. The record is emptied by every data access, so a second data access without a new status read clears nothing.
- R4: A status read with only one byte lane enabled (be_i = 01 or 10) records all 16 bits. A status access with be_i = 00 is not a status read.
- R5: A combined read (addr 3) returns the receive holding value and clears the receive full, idle and overrun bits set in that cycle. It does not clear status bits 8 and 9, and it empties the record.
- R6: Bit 8 is set when the transmit engine accepts data, and is cleared only by a data write after a status read that recorded it. Bit 9 is set by a tx_done_i pulse and is cleared by such a recorded data write or when the engine accepts new data.
- R7: A write to addr 2 loads the transmit holding register and raises tx_valid_o. tx_valid_o and tx_data_o hold until a cycle with tx_ready_i high.
- R8: With control bit 4 set, data bit 8 passes in both directions. With it clear, bit 8 reads as 0 and is written as 0.
- R9: rx_valid_i loads the receive holding register and sets bit 0. If bit 0 is already set, the holding register keeps its value and bit 2 (overrun) is set.
- R10: irq_o is the OR of the flag/enable pairs (bit 0 with enable 0, bit 1 with enable 1, bit 8 with enable 2, bit 9 with enable 3), registered one cycle after the flags.
- R11: When a set pulse and a clear for the same flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| be_i | input | 2 | Byte lanes of a status read |
| wdata_i | input | 9 | Write data |
| rdata_o | output | 16 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Combined interrupt request |
| rx_valid_i | input | 1 | Receive engine delivers a word |
| rx_data_i | input | 9 | Received word |
| idle_i | input | 1 | Receive engine saw an idle line |
| tx_done_i | input | 1 | Transmit engine finished a frame |
| tx_valid_o | output | 1 | Transmit holding register has data |
| tx_data_o | output | 9 | Transmit holding register contents |
| tx_ready_i | input | 1 | Transmit engine takes the held word |

## Verification
The bench goes after a flag raised between the status read and the data access. A design that cleared all set flags, or that kept no snapshot, would lose that idle or receive event. It repeats data accesses without a new status read, which catches a record that is never emptied. It reads status through a single byte lane, checks that a combined read keeps the transmit flags (a wrong design would drop transmit-empty), and lines up a receive pulse with a clearing access, where a clear-over-set priority would lose the word's flag.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int unsigned ST_W = 16;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_BOTH = 2'd3
  } addr_e;

  localparam int unsigned B_RXF  = 0;
  localparam int unsigned B_IDLE = 1;
  localparam int unsigned B_OVR  = 2;
  localparam int unsigned B_TXE  = 8;
  localparam int unsigned B_TXC  = 9;

  localparam logic [ST_W-1:0] RX_MASK  = 16'h0007;
  localparam logic [ST_W-1:0] TX_MASK  = 16'h0300;
  localparam logic [ST_W-1:0] IMPL     = RX_MASK | TX_MASK;
  localparam logic [ST_W-1:0] ST_RESET = 16'h0300;

  typedef struct packed {
    logic nine;
    logic txc_en;
    logic txe_en;
    logic idle_en;
    logic rx_en;
  } ctrl_t;
endpackage

// File: rtl/uart_regif_flags.sv
module uart_regif_flags
  import uart_regif_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stat_rd_i,
  input  logic            data_rd_i,
  input  logic            data_wr_i,
  input  logic            both_rd_i,
  input  logic [ST_W-1:0] set_i,
  input  logic            txc_clr_i,
  output logic [ST_W-1:0] flags_o
);
  logic [ST_W-1:0] flags_q, mask_q, clr;
  logic            acc;

  assign acc = data_rd_i | data_wr_i;

  always_comb begin
    clr = '0;
    if (acc)       clr = clr | (mask_q & RX_MASK);
    if (data_wr_i) clr = clr | (mask_q & TX_MASK);
    if (both_rd_i) clr = clr | (flags_q & RX_MASK);
    clr[B_TXC] = clr[B_TXC] | txc_clr_i;
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= ST_RESET;
    else         flags_q <= (set_i | (flags_q & ~clr)) & IMPL;
  end

  // snapshot of flags seen by the last status read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               mask_q <= '0;
    else if (stat_rd_i)        mask_q <= flags_q;
    else if (acc || both_rd_i) mask_q <= '0;
  end

  assign flags_o = flags_q;

  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[B_RXF] |=> flags_q[B_RXF]);
  assert_mask_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc || both_rd_i) |=> (mask_q == '0));
  assert_unseen_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && flags_q[B_IDLE] && !mask_q[B_IDLE]) |=> flags_q[B_IDLE]);
  assert_both_keeps_tx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_rd_i && flags_q[B_TXE]) |=> flags_q[B_TXE]);
  assert_read_keeps_txe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && flags_q[B_TXE]) |=> flags_q[B_TXE]);
endmodule

// File: rtl/uart_regif_data.sv
module uart_regif_data #(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nine_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_full_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              ovr_set_o,
  output logic              tx_take_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o
);
  localparam int unsigned LOW_W = DATA_W - 1;

  logic [DATA_W-1:0] wmask, rx_q, tx_q;
  logic              pend_q;

  assign wmask = nine_i ? '1 : {1'b0, {LOW_W{1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rx_q <= '0;
    else if (rx_valid_i && !rx_full_i) rx_q <= rx_data_i;
  end

  assign rx_word_o = rx_q & wmask;
  assign ovr_set_o = rx_valid_i & rx_full_i;
  assign tx_take_o = pend_q & tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      pend_q <= 1'b0;
    end else if (data_wr_i) begin
      tx_q   <= wdata_i & wmask;
      pend_q <= 1'b1;
    end else if (tx_take_o) begin
      pend_q <= 1'b0;
    end
  end

  assign tx_valid_o = pend_q;
  assign tx_data_o  = tx_q;

  assert_tx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !data_wr_i) |=> (tx_valid_o && $stable(tx_data_o)));
  assert_rx_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_i && !nine_i) |=> (nine_i || $stable(rx_word_o)));
endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             irq_o
);
  logic [N_SRC-1:0] hit;
  logic             irq_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_pair
    assign hit[i] = src_i[i] & en_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |hit;
  end

  assign irq_o = irq_q;

  assert_irq_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |=> !irq_o);
  assert_irq_nosrc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |=> !irq_o);
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [1:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ST_W-1:0]   rdata_o,
  output logic              irq_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              idle_i,
  input  logic              tx_done_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned PAD_W  = ST_W - DATA_W;

  ctrl_t             ctl_q;
  logic              rd, stat_rd, data_rd, data_wr, both_rd, ctl_wr;
  logic [ST_W-1:0]   flags, set_v;
  logic [DATA_W-1:0] rx_word;
  logic              ovr_set, tx_take;

  assign rd      = req_i & ~we_i;
  assign stat_rd = rd & (addr_i == A_STAT) & (|be_i);
  assign data_rd = rd & (addr_i == A_DATA);
  assign both_rd = rd & (addr_i == A_BOTH);
  assign data_wr = req_i & we_i & (addr_i == A_DATA);
  assign ctl_wr  = req_i & we_i & (addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  always_comb begin
    set_v         = '0;
    set_v[B_RXF]  = rx_valid_i;
    set_v[B_IDLE] = idle_i;
    set_v[B_OVR]  = ovr_set;
    set_v[B_TXE]  = tx_take;
    set_v[B_TXC]  = tx_done_i;
  end

  uart_regif_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stat_rd_i (stat_rd),
    .data_rd_i (data_rd),
    .data_wr_i (data_wr),
    .both_rd_i (both_rd),
    .set_i     (set_v),
    .txc_clr_i (tx_take),
    .flags_o   (flags)
  );

  uart_regif_data #(.DATA_W(DATA_W)) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nine_i     (ctl_q.nine),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_full_i  (flags[B_RXF]),
    .data_wr_i  (data_wr),
    .wdata_i    (wdata_i),
    .tx_ready_i (tx_ready_i),
    .rx_word_o  (rx_word),
    .ovr_set_o  (ovr_set),
    .tx_take_o  (tx_take),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o)
  );

  uart_regif_irq #(.N_SRC(4)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  ({flags[B_TXC], flags[B_TXE], flags[B_IDLE], flags[B_RXF]}),
    .en_i   ({ctl_q.txc_en, ctl_q.txe_en, ctl_q.idle_en, ctl_q.rx_en}),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {{(ST_W-CTRL_W){1'b0}}, ctl_q};
      A_STAT:  rdata_o = flags;
      default: rdata_o = {{PAD_W{1'b0}}, rx_word};
    endcase
  end

  assert_stat_rd_keeps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !rx_valid_i && !idle_i && !tx_done_i && !tx_take) |=> $stable(flags));
  assert_take_sets_txe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i) |=> flags[B_TXE]);
endmodule

// File: tb/tb_uart_regif.sv
module tb_uart_regif;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 0, we_i = 0;
  logic [1:0] addr_i = 0, be_i = 0;
  logic [8:0] wdata_i = 0;
  logic [15:0] rdata_o;
  logic       irq_o;
  logic       rx_valid_i = 0;
  logic [8:0] rx_data_i = 0;
  logic       idle_i = 0, tx_done_i = 0, tx_ready_i = 0;
  logic       tx_valid_o;
  logic [8:0] tx_data_o;

  int checks = 0, fails = 0;
  bit done = 0;

  uart_regif dut (.*);

  always #4 clk_i = ~clk_i;

  // reference state
  logic [15:0] m_flags = 16'h0300, m_mask = 0;
  logic [4:0]  m_ctl = 0;
  logic [8:0]  m_rx = 0, m_txh = 0;
  logic        m_pend = 0, m_irq = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {11'b0, m_ctl};
      2'd1:    return m_flags;
      default: return {7'b0, m_ctl[4] ? m_rx[8] : 1'b0, m_rx[7:0]};
    endcase
  endfunction

  task automatic cyc(input logic rq, input logic w, input logic [1:0] a, input logic [1:0] b,
                     input logic [8:0] wd, input logic rxv, input logic [8:0] rxd,
                     input logic idl, input logic txd, input logic txr, input string tag);
    logic st, drd, dwr, both, cw, hs, acc;
    logic [15:0] clr, set, nf, nm;
    @(negedge clk_i);
    req_i = rq; we_i = w; addr_i = a; be_i = b; wdata_i = wd;
    rx_valid_i = rxv; rx_data_i = rxd; idle_i = idl; tx_done_i = txd; tx_ready_i = txr;
    #1;
    if (rq && !w) chk(tag, rdata_o, exp_rd(a));
    st   = rq & !w & (a == 2'd1) & (|b);
    drd  = rq & !w & (a == 2'd2);
    dwr  = rq & w & (a == 2'd2);
    both = rq & !w & (a == 2'd3);
    cw   = rq & w & (a == 2'd0);
    hs   = m_pend & txr;
    acc  = drd | dwr;
    clr = 0;
    if (acc)  clr = clr | (m_mask & 16'h0007);
    if (dwr)  clr = clr | (m_mask & 16'h0300);
    if (both) clr = clr | (m_flags & 16'h0007);
    if (hs)   clr[9] = 1'b1;
    set = 0;
    set[0] = rxv; set[1] = idl; set[2] = rxv & m_flags[0]; set[8] = hs; set[9] = txd;
    nf = (m_flags & ~clr) | set;
    nm = st ? m_flags : ((acc | both) ? 16'h0 : m_mask);
    @(posedge clk_i);
    m_irq = |({m_flags[9], m_flags[8], m_flags[1], m_flags[0]} & m_ctl[3:0]);
    if (rxv && !m_flags[0]) m_rx = rxd;
    if (dwr) begin
      m_txh  = m_ctl[4] ? wd : {1'b0, wd[7:0]};
      m_pend = 1'b1;
    end else if (hs) m_pend = 1'b0;
    if (cw) m_ctl = wd[4:0];
    m_flags = nf;
    m_mask  = nm;
    #2;
    chk({tag, " R10 irq"}, {15'b0, irq_o}, {15'b0, m_irq});
    chk({tag, " R7 tx_valid"}, {15'b0, tx_valid_o}, {15'b0, m_pend});
    if (m_pend) chk({tag, " R7 tx_data"}, {7'b0, tx_data_o}, {7'b0, m_txh});
  endtask

  task automatic idle_cyc(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rd(input logic [1:0] a, input string tag);
    cyc(1, 0, a, 2'b11, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input logic [1:0] a, input logic [8:0] d, input string tag);
    cyc(1, 1, a, 2'b11, d, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rx(input logic [8:0] d, input string tag);
    cyc(0, 0, 0, 0, 0, 1, d, 0, 0, 0, tag);
  endtask

  initial begin
    #5000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #1;
    chk("R1 status", rdata_o & 16'h0, 16'h0);
    rd(1, "R1 status reset");
    chk("R1 status literal", rdata_o, 16'h0300);
    rd(0, "R1 control reset");
    chk("R1 irq", {15'b0, irq_o}, 16'h0);
    chk("R1 tx_valid", {15'b0, tx_valid_o}, 16'h0);

    // R9 + R2 + R8 (8-bit)
    rx(9'h1A5, "R9 load");
    rd(1, "R9 status full");
    rd(2, "R8 eight-bit read");
    rd(1, "R2 cleared");
    chk("R2 literal", rdata_o, 16'h0300);

    // R8 nine-bit
    wr(0, 9'h010, "R8 mode");
    rx(9'h1A5, "R8 rx");
    rd(1, "R8 snap");
    rd(2, "R8 nine-bit read");
    chk("R8 literal", rdata_o, 16'h01A5);

    // R3: set between steps survives, repeated access clears nothing
    rx(9'h033, "R3 rx");
    rd(1, "R3 snap");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R3 idle pulse");
    rd(2, "R3 data");
    rd(1, "R3 idle kept");
    chk("R3 literal", rdata_o, 16'h0302);
    rd(2, "R3 data again");
    wr(2, 9'h0, "R3 stray write");
    rd(1, "R3 snap2");
    rd(2, "R3 data2");
    rd(1, "R3 cleared");

    // R4: single lane status reads
    rx(9'h044, "R4 rx");
    cyc(1, 0, 1, 2'b10, 0, 0, 0, 0, 0, 0, "R4 upper lane");
    rd(2, "R4 data");
    rd(1, "R4 cleared");
    rx(9'h045, "R4 rx2");
    cyc(1, 0, 1, 2'b00, 0, 0, 0, 0, 0, 0, "R4 no lane");
    rd(2, "R4 data2");
    rd(1, "R4 kept");
    cyc(1, 0, 1, 2'b01, 0, 0, 0, 0, 0, 0, "R4 lower lane");
    rd(2, "R4 data3");
    rd(1, "R4 cleared2");

    // R9 overrun, R5 combined read
    idle_cyc("R5 settle");
    rx(9'h0AA, "R9 first");
    rx(9'h055, "R9 overrun");
    rd(1, "R9 overrun flags");
    rd(3, "R5 combined");
    chk("R5 keeps data", rdata_o, 16'h00AA);
    rd(1, "R5 tx flags kept");

    // R6/R7 transmit path
    rd(1, "R6 snap");
    wr(2, 9'h155, "R7 write");
    rd(1, "R6 tx flags cleared");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 hold");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R6 take");
    rd(1, "R6 empty set");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R6 done pulse");
    rd(1, "R6 snap2");
    rd(2, "R6 read no clear");
    rd(1, "R6 empty kept");

    // R10 irq, R11 set vs clear
    wr(0, 9'h00F, "R10 enable");
    rx(9'h011, "R10 rx");
    idle_cyc("R10 irq");
    rd(1, "R11 snap");
    cyc(1, 0, 2, 2'b11, 0, 1, 9'h012, 0, 0, 0, "R11 clear with set");
    rd(1, "R11 flag kept");
    wr(0, 9'h000, "R10 disable");
    idle_cyc("R10 off");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic rq, w;
      logic [1:0] a, b;
      rq = ($urandom % 3) != 0;
      w  = ($urandom % 4) == 0;
      a  = 2'($urandom);
      b  = 2'($urandom);
      cyc(rq, w, a, b, 9'($urandom), ($urandom % 5) == 0, 9'($urandom),
          ($urandom % 16) == 0, ($urandom % 8) == 0, ($urandom % 3) == 0,
          "R2 R3 R5 R6 R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule